// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counting channel for a programmable interval timer. The host side presents a new initial count together with a 3-bit mode and a BCD flag on a one-cycle load strobe. After that the channel advances once for each cycle in which the counting-clock enable `tick` is high. The `gate` input can suspend counting or retrigger the sequence, depending on the mode. The channel drives one output line and shows its live count, so that a surrounding register file can latch the count or assemble a status byte from `out_o`, `mode_o` and `bcd_o`.

Six behaviours are supported:
- Mode 0: interrupt on terminal count.
- Mode 1: gate-retriggered one-shot.
- Mode 2: periodic rate pulse.
- Mode 3: square wave.
- Mode 4: software strobe.
- Mode 5: gate-retriggered strobe.

Mode codes 6 and 7 act as 2 and 3. A programmed count of zero stands for 65536. Every load starts counting at once, in every mode. The BCD flag is only stored and shown; counting is always binary.

The load strobe and `tick` are plain control pins. The channel accepts a load in every cycle, and a load always takes priority over counting. There is no back-pressure.

Top module: `pit_counter_channel`

## Requirements
- R1: After reset `count_o` is 0, `out_o` is 1 and `mode_o` is 0. The count does not change until the first load, whatever `tick` and `gate` do.
- R2: A load strobe makes `count_o` equal to `ld_count` in the next cycle. In mode 3 an odd count is first raised by one. `mode_o` and `bcd_o` show the loaded values. A count of 0 means 65536. Mode codes 6 and 7 behave exactly as 2 and 3.
- R3: In mode 0, each tick decrements the count modulo 65536. `out_o` is 0 from the load until N ticks have elapsed, then stays 1, including after the count wraps.
- R4: In modes 0 and 4, a tick while `gate` is low leaves the count unchanged. A rising `gate` in these modes does not reload the count.
- R5: In mode 4, the count decrements modulo 65536. `out_o` is 0 only during the tick interval that follows the count first reaching 0 (d = N ticks after the load) and is 1 otherwise.
- R6: In modes 1 and 5, counting ignores the `gate` level. A rising `gate` reloads N at the next tick and restarts the sequence. In mode 1, `out_o` is 0 until N ticks after the load or trigger, then 1. In mode 5, `out_o` is 0 only at d = N.
- R7: In mode 2, the count runs N, N-1, ..., 1 and then reloads N, with period N ticks. `out_o` is 0 exactly while the count is 1.
- R8: In mode 3, with H = ceil(N/2), the count starts at N rounded up to even and steps down by two. It reloads at 2 and the phase toggles. `out_o` is 1 for H ticks, then 0 for N - H ticks, and repeats. For the low half the reload is N rounded down to even. N must be at least 2.
- R9: In modes 2 and 3, a low `gate` forces `out_o` to 1 and freezes the count. A rising `gate` reloads the count at the next tick, starting with the high phase.
- R10: In a cycle with `tick` low and no load, the count and output state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting-clock enable; one count step per high cycle |
| gate | input | 1 | Gate input, level and rising-edge sensitive by mode |
| ld_stb | input | 1 | Load strobe for a new count and mode |
| ld_count | input | 16 | Initial count, 0 meaning 65536 |
| ld_mode | input | 3 | Counting mode code |
| ld_bcd | input | 1 | BCD flag, stored only |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Channel output line |
| mode_o | output | 3 | Mode code as loaded |
| bcd_o | output | 1 | BCD flag as loaded |

## Verification
The assertions check the following on every cycle:
- The loaded count appears one cycle after the strobe.
- The count stays even in mode 3.
- A low gate in modes 0 and 4 freezes the count.
- The mode 4 and mode 5 strobe never lasts past one tick.
- A mode 0 output never falls except on a load.
- An idle `tick` leaves the state alone.

Some behaviour only the bench scenarios can show: the exact count and output sequence for each mode and count, the asymmetric halves of an odd square wave, the 65536 wrap, gate retriggering in modes 1, 2, 3 and 5, and the aliasing of modes 6 and 7.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [2:0] {
    M_TERM   = 3'd0,
    M_ONESHT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTRB = 3'd4,
    M_HWSTRB = 3'd5
  } cmode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic cmode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return cmode_e'({1'b0, code[1:0]});
    return cmode_e'(code);
  endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic tick,
  input  logic clr,
  output logic trig
);
  logic gate_q;
  logic pend_q;
  logic rise;

  assign rise = gate & ~gate_q;
  assign trig = rise | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (clr || tick) pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          trig,
  input  logic          ld_stb,
  input  logic [CW-1:0] ld_count,
  input  logic [2:0]    ld_mode,
  output logic [CW-1:0] count,
  output cmode_e        mode_q,
  output logic          done,
  output logic          strobe,
  output logic          phase
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] init_q;
  logic          run_q;
  logic [CW-1:0] sq_hi, sq_lo, ld_sq_hi;
  cmode_e        ld_eff;
  logic          gate_free, step_en, retrig, hit;

  assign ld_eff    = fold_mode(ld_mode);
  assign sq_hi     = init_q + CW'(init_q[0]);
  assign sq_lo     = init_q - CW'(init_q[0]);
  assign ld_sq_hi  = ld_count + CW'(ld_count[0]);
  assign gate_free = (mode_q == M_ONESHT) || (mode_q == M_HWSTRB);
  assign step_en   = gate_free | gate;
  assign retrig    = trig && (mode_q != M_TERM) && (mode_q != M_SWSTRB) && step_en;
  assign hit       = (count == ONE) && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      init_q <= '0;
      mode_q <= M_TERM;
      run_q  <= 1'b0;
      done   <= 1'b1;
      strobe <= 1'b0;
      phase  <= 1'b1;
    end else if (ld_stb) begin
      init_q <= ld_count;
      mode_q <= ld_eff;
      run_q  <= 1'b1;
      done   <= 1'b0;
      strobe <= 1'b0;
      phase  <= 1'b1;
      count  <= (ld_eff == M_SQUARE) ? ld_sq_hi : ld_count;
    end else if (tick && run_q) begin
      if (retrig) begin
        count  <= (mode_q == M_SQUARE) ? sq_hi : init_q;
        done   <= 1'b0;
        strobe <= 1'b0;
        phase  <= 1'b1;
      end else if (step_en) begin
        unique case (mode_q)
          M_RATE: count <= (count == ONE) ? init_q : count - ONE;
          M_SQUARE: begin
            if (count == TWO) begin
              phase <= ~phase;
              count <= phase ? sq_lo : sq_hi;
            end else begin
              count <= count - TWO;
            end
          end
          default: begin
            count  <= count - ONE;
            strobe <= hit;
            if (hit) done <= 1'b1;
          end
        endcase
      end else begin
        strobe <= 1'b0;
      end
    end
  end

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !gate && !ld_stb && (mode_q == M_TERM || mode_q == M_SWSTRB))
    |=> $stable(count));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && tick && !ld_stb) |=> !strobe);

  assert_square_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE) |-> !count[0]);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_stb) |=> ($stable(count) && $stable(done) && $stable(phase)));
endmodule

// File: rtl/pit_out_decode.sv
module pit_out_decode
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  cmode_e        mode_q,
  input  logic [CW-1:0] count,
  input  logic          gate,
  input  logic          done,
  input  logic          strobe,
  input  logic          phase,
  output logic          out
);
  always_comb begin
    unique case (mode_q)
      M_TERM, M_ONESHT:   out = done;
      M_RATE:             out = ~gate | (count != CW'(1));
      M_SQUARE:           out = ~gate | phase;
      M_SWSTRB, M_HWSTRB: out = ~strobe;
      default:            out = 1'b1;
    endcase
  end
endmodule

// File: rtl/pit_counter_channel.sv
module pit_counter_channel
  import pit_chan_pkg::*;
#(
  parameter int CW = 16,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          ld_stb,
  input  logic [CW-1:0] ld_count,
  input  logic [MW-1:0] ld_mode,
  input  logic          ld_bcd,
  output logic [CW-1:0] count_o,
  output logic          out_o,
  output logic [MW-1:0] mode_o,
  output logic          bcd_o
);
  logic   trig, done, strobe, phase;
  cmode_e eff_mode;

  pit_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .gate(gate), .tick(tick), .clr(ld_stb), .trig(trig)
  );

  pit_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .trig(trig),
    .ld_stb(ld_stb), .ld_count(ld_count), .ld_mode(ld_mode),
    .count(count_o), .mode_q(eff_mode), .done(done), .strobe(strobe), .phase(phase)
  );

  pit_out_decode #(.CW(CW)) u_dec (
    .mode_q(eff_mode), .count(count_o), .gate(gate), .done(done),
    .strobe(strobe), .phase(phase), .out(out_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= '0;
      bcd_o  <= 1'b0;
    end else if (ld_stb) begin
      mode_o <= ld_mode;
      bcd_o  <= ld_bcd;
    end
  end

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && fold_mode(ld_mode) != M_SQUARE) |=> (count_o == $past(ld_count)));

  assert_term_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == M_TERM && $fell(out_o)) |-> $past(ld_stb));
endmodule

// File: tb/sim_pit_counter_channel.sv
module sim_pit_counter_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        gate = 1'b1;
  logic        ld_stb = 1'b0;
  logic [15:0] ld_count = '0;
  logic [2:0]  ld_mode = '0;
  logic        ld_bcd = 1'b0;
  logic [15:0] count_o;
  logic        out_o;
  logic [2:0]  mode_o;
  logic        bcd_o;
  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  pit_counter_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .ld_stb(ld_stb),
    .ld_count(ld_count), .ld_mode(ld_mode), .ld_bcd(ld_bcd),
    .count_o(count_o), .out_o(out_o), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int k = 1);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load(input int n, input int m, input bit b = 1'b0);
    ld_stb = 1'b1; ld_count = 16'(n); ld_mode = 3'(m); ld_bcd = b;
    @(posedge clk);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  function automatic int nfull(input int n);
    return (n == 0) ? 65536 : n;
  endfunction

  function automatic int exp_cnt(input int m, input int n, input int d);
    int nf = nfull(n);
    int h = (nf + 1) / 2;
    int r;
    case (m)
      2: return (nf - (d % nf)) & 16'hFFFF;
      3: begin
        r = d % nf;
        if (r < h) return (nf + (nf & 1) - 2 * r) & 16'hFFFF;
        return (nf - (nf & 1) - 2 * (r - h)) & 16'hFFFF;
      end
      default: return (nf - d) & 16'hFFFF;
    endcase
  endfunction

  function automatic int exp_out(input int m, input int n, input int d);
    int nf = nfull(n);
    case (m)
      0, 1: return (d >= nf) ? 1 : 0;
      2: return (exp_cnt(m, n, d) != 1) ? 1 : 0;
      3: return ((d % nf) < (nf + 1) / 2) ? 1 : 0;
      default: return (d != nf) ? 1 : 0;
    endcase
  endfunction

  function automatic string rq(input int m);
    case (m)
      0: return "R3";
      1: return "R6 mode1";
      2: return "R7";
      3: return "R8";
      4: return "R5";
      default: return "R6 mode5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(2);
    rst_n = 1'b1;
    // R1 reset state, no counting before a load
    chk("R1 count", count_o, 0);
    chk("R1 out", out_o, 1);
    chk("R1 mode", mode_o, 0);
    step(5);
    chk("R1 idle count", count_o, 0);

    // sweep every mode over small counts
    for (int m = 0; m < 6; m++) begin
      for (int n = 1; n <= 9; n++) begin
        if (m == 3 && n == 1) continue;
        load(n, m);
        for (int d = 0; d <= 2 * n + 3; d++) begin
          chk({rq(m), " count"}, count_o, exp_cnt(m, n, d));
          chk({rq(m), " out"}, out_o, exp_out(m, n, d));
          step();
        end
      end
    end

    // R2 / R3: zero means 65536, wrap without a second terminal event
    load(0, 0);
    chk("R2 zero load", count_o, 0);
    step();
    chk("R3 wrap count", count_o, 16'hFFFF);
    step(65534);
    chk("R3 before terminal count", count_o, 1);
    chk("R3 before terminal out", out_o, 0);
    step();
    chk("R3 terminal out", out_o, 1);
    chk("R3 terminal count", count_o, 0);
    step(3);
    chk("R3 sticky out", out_o, 1);
    load(0, 3);
    step();
    chk("R8 65536 count", count_o, 16'hFFFE);
    chk("R8 65536 out", out_o, 1);

    // R2 aliases and stored flags
    load(3, 6, 1'b1);
    chk("R2 mode_o", mode_o, 6);
    chk("R2 bcd_o", bcd_o, 1);
    for (int d = 0; d < 7; d++) begin
      chk("R2 alias6 count", count_o, exp_cnt(2, 3, d));
      chk("R2 alias6 out", out_o, exp_out(2, 3, d));
      step();
    end
    load(5, 7);
    chk("R2 mode_o 7", mode_o, 7);
    for (int d = 0; d < 11; d++) begin
      chk("R2 alias7 count", count_o, exp_cnt(3, 5, d));
      chk("R2 alias7 out", out_o, exp_out(3, 5, d));
      step();
    end
    // R2 reload mid sequence
    load(7, 2);
    step(3);
    load(4, 2);
    chk("R2 restart", count_o, 4);

    // R4 gate in mode 0
    load(10, 0);
    step(3);
    gate = 1'b0;
    step(4);
    chk("R4 mode0 frozen", count_o, 7);
    gate = 1'b1;
    step(2);
    chk("R4 mode0 no retrigger", count_o, 5);
    // R4 gate in mode 4
    load(3, 4);
    gate = 1'b0;
    step(5);
    chk("R4 mode4 frozen", count_o, 3);
    chk("R4 mode4 out", out_o, 1);
    gate = 1'b1;
    step(3);
    chk("R4 mode4 resumes out", out_o, 0);

    // R6 mode 1 retrigger
    load(4, 1);
    step(6);
    chk("R6 mode1 expired", out_o, 1);
    gate = 1'b0;
    step();
    chk("R6 mode1 gate level ignored", count_o, 16'hFFFD);
    gate = 1'b1;
    step();
    chk("R6 mode1 retrig count", count_o, 4);
    chk("R6 mode1 retrig out", out_o, 0);
    step(4);
    chk("R6 mode1 end count", count_o, 0);
    chk("R6 mode1 end out", out_o, 1);
    // R6 mode 5 retrigger
    load(3, 5);
    step(5);
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    chk("R6 mode5 retrig count", count_o, 3);
    chk("R6 mode5 retrig out", out_o, 1);
    step(3);
    chk("R6 mode5 strobe", out_o, 0);
    step();
    chk("R6 mode5 strobe end", out_o, 1);

    // R9 mode 2 gate
    load(4, 2);
    step(3);
    chk("R9 mode2 count at 1", count_o, 1);
    gate = 1'b0;
    #1;
    chk("R9 mode2 out forced", out_o, 1);
    step(2);
    chk("R9 mode2 frozen", count_o, 1);
    gate = 1'b1;
    step();
    chk("R9 mode2 reload", count_o, 4);
    step();
    chk("R9 mode2 continue", count_o, 3);
    // R9 mode 3 gate
    load(6, 3);
    step(4);
    chk("R9 mode3 low phase", out_o, 0);
    gate = 1'b0;
    #1;
    chk("R9 mode3 out forced", out_o, 1);
    step(2);
    chk("R9 mode3 frozen", count_o, 4);
    gate = 1'b1;
    step();
    chk("R9 mode3 reload", count_o, 6);
    chk("R9 mode3 high", out_o, 1);
    step();
    chk("R9 mode3 continue", count_o, 4);

    // R10 tick low
    load(20, 0);
    tick = 1'b0;
    step(5);
    chk("R10 count held", count_o, 20);
    chk("R10 out held", out_o, 0);
    tick = 1'b1;
    step();
    chk("R10 resume", count_o, 19);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule